// File: doc/BRIEF.md
# Subtractive Euclidean GCD Unit

This block finds the greatest common divisor of two unsigned integers. It uses only comparison and subtraction, with no divider. A small state machine sequences the work. A datapath holds the two working registers, one shared subtractor, a magnitude comparator and the routing multiplexers. The controller steers the datapath through a compact bundle of strobes. The datapath reports its comparison flags back to the controller.

A caller raises `start` for one cycle with the first operand on `dataIn`, then puts the second operand on the same bus in the next cycle. The unit then alternates a compare cycle with a subtract cycle. Each subtract cycle replaces the larger register with the difference of the two. When the registers agree, `done` rises and `result` carries the common value. A zero operand ends the calculation at once, so the loop can never spin forever. The flag and the value stay put until the caller starts the next calculation.

Top module: `gcd_unit`

## Requirements
- R1: A synchronous active-high `rst` puts the unit in its load state. There `done` is low, and it stays low while `start` is low.
- R2: In the load state, or while `done` is high, a cycle with `start` high captures `dataIn` as the first operand. The next cycle captures `dataIn` as the second operand whatever `start` is. A `start` pulse during the iteration is ignored.
- R3: Compare and subtract cycles alternate. In a subtract cycle exactly one register changes: the larger one takes the difference larger minus smaller, and the other register keeps its value.
- R4: When the two registers are equal in a compare cycle, `done` rises on the next edge and `result` equals that common value. The operands 4 and 24 give 4.
- R5: If exactly one operand is zero, `result` is the other operand. If both are zero, `result` is 0. In both cases no subtract cycle is spent.
- R6: While `done` is high and `start` stays low, `done` stays high and `result` holds its value, whatever `dataIn` does. A `start` in that state begins a new calculation and drops `done` on the same edge.
- R7: `result` equals the mathematical GCD of the operands for every operand pair, including equal, coprime, one-valued and all-ones operands.
- R8: `done` first reads high 1 + 2k clock edges after the edge that captures the second operand, where k is the number of subtractions the algorithm needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a calculation; qualifies the first operand on `dataIn` |
| dataIn | input | WIDTH | Shared operand bus: first operand with `start`, second operand one cycle later |
| done | output | 1 | High while the result is valid |
| result | output | WIDTH | Greatest common divisor; valid while `done` is high |

## Verification
The bench builds the unit with WIDTH set to 8 rather than the default 16. At that width the slowest cases are within reach of a short run: the all-ones operand paired with 1 needs 254 subtractions, and at 16 bits the same case would need tens of thousands. The narrower width also lets random pairs cover the whole operand range, so the all-ones and zero boundaries are hit directly. The same width makes the cycle count of every case exact and cheap to predict.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [2:0] {
    ST_GET_A   = 3'd0,
    ST_GET_B   = 3'd1,
    ST_COMPARE = 3'd2,
    ST_SUB_A   = 3'd3,
    ST_SUB_B   = 3'd4,
    ST_FINISH  = 3'd5
  } gcd_state_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic ldA;       // write register A
    logic ldB;       // write register B
    logic selMinB;   // subtractor minuend: 0 = A, 1 = B
    logic selSubA;   // subtractor subtrahend: 0 = B, 1 = A
    logic selDiff;   // register source: 0 = dataIn, 1 = difference
  } gcd_ctrl_t;

  // status from the datapath to the controller
  typedef struct packed {
    logic aLess;
    logic aGreater;
    logic aEqual;
    logic aZero;
    logic bZero;
  } gcd_flags_t;

endpackage

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  gcd_ctrl_t        ctrl,
  output gcd_flags_t       flags,
  output logic [WIDTH-1:0] opA,
  output logic [WIDTH-1:0] opB
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] minuend;
  logic [WIDTH-1:0] subtrahend;
  logic [WIDTH-1:0] difference;
  logic [WIDTH-1:0] loadValue;

  // operand routing into the single subtractor
  always_comb begin
    minuend    = ctrl.selMinB ? opB : opA;
    subtrahend = ctrl.selSubA ? opA : opB;
  end

  assign difference = minuend - subtrahend;
  assign loadValue  = ctrl.selDiff ? difference : dataIn;

  // magnitude comparator and zero detect
  always_comb begin
    flags.aLess    = (opA < opB);
    flags.aGreater = (opA > opB);
    flags.aEqual   = (opA == opB);
    flags.aZero    = (opA == ZERO);
    flags.bZero    = (opB == ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= ZERO;
    end else if (ctrl.ldA) begin
      opA <= loadValue;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opB <= ZERO;
    end else if (ctrl.ldB) begin
      opB <= loadValue;
    end
  end

endmodule

// File: rtl/gcd_control.sv
module gcd_control
  import gcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  gcd_flags_t flags,
  output gcd_ctrl_t  ctrl,
  output gcd_state_t curState,
  output logic       doneFlag
);

  gcd_state_t nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_GET_A;
    end else begin
      curState <= nextState;
    end
  end

  always_comb begin
    nextState = curState;
    ctrl      = '0;
    doneFlag  = 1'b0;
    unique case (curState)
      ST_GET_A: begin
        if (start) begin
          ctrl.ldA  = 1'b1;
          nextState = ST_GET_B;
        end
      end
      ST_GET_B: begin
        ctrl.ldB  = 1'b1;
        nextState = ST_COMPARE;
      end
      ST_COMPARE: begin
        if (flags.aZero && !flags.bZero) begin
          // B - 0 = B moves the surviving operand into A
          ctrl.ldA     = 1'b1;
          ctrl.selMinB = 1'b1;
          ctrl.selSubA = 1'b1;
          ctrl.selDiff = 1'b1;
          nextState    = ST_FINISH;
        end else if (flags.bZero || flags.aEqual) begin
          nextState = ST_FINISH;
        end else if (flags.aGreater) begin
          nextState = ST_SUB_A;
        end else if (flags.aLess) begin
          nextState = ST_SUB_B;
        end
      end
      ST_SUB_A: begin
        ctrl.ldA     = 1'b1;
        ctrl.selDiff = 1'b1;
        nextState    = ST_COMPARE;
      end
      ST_SUB_B: begin
        ctrl.ldB     = 1'b1;
        ctrl.selMinB = 1'b1;
        ctrl.selSubA = 1'b1;
        ctrl.selDiff = 1'b1;
        nextState    = ST_COMPARE;
      end
      ST_FINISH: begin
        doneFlag = 1'b1;
        if (start) begin
          ctrl.ldA  = 1'b1;
          nextState = ST_GET_B;
        end
      end
      default: nextState = ST_GET_A;
    endcase
  end

endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  gcd_ctrl_t        ctrlBus;
  gcd_flags_t       flagBus;
  gcd_state_t       ctrlState;
  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;

  gcd_control u_control (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .flags    (flagBus),
    .ctrl     (ctrlBus),
    .curState (ctrlState),
    .doneFlag (done)
  );

  gcd_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .ctrl   (ctrlBus),
    .flags  (flagBus),
    .opA    (regA),
    .opB    (regB)
  );

  assign result = regA;

endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] dataIn,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input gcd_state_t       ctrlState,
  input logic [WIDTH-1:0] regA,
  input logic [WIDTH-1:0] regB
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!done && ctrlState == ST_GET_A)); // R1

  AST_B_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_GET_B |=> regB == $past(dataIn)); // R2

  AST_SUB_A_STEP: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_SUB_A |=> (regA == $past(regA) - $past(regB)) && $stable(regB)); // R3

  AST_SUB_B_STEP: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_SUB_B |=> (regB == $past(regB) - $past(regA)) && $stable(regA)); // R3

  AST_SUB_RETURN: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_SUB_A || ctrlState == ST_SUB_B) |=> ctrlState == ST_COMPARE); // R3

  AST_DONE_AGREE: assert property (@(posedge clk) disable iff (rst)
    done |-> (regA == regB || regB == '0)); // R4

  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_COMPARE && regA == '0) |=> (done && result == $past(regB))); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result))); // R6

endmodule

bind gcd_unit gcd_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dataIn    (dataIn),
  .done      (done),
  .result    (result),
  .ctrlState (ctrlState),
  .regA      (regA),
  .regB      (regB)
);

// File: tb/test_gcd_unit.sv
module test_gcd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int NVEC       = 14;
  localparam int CALC_LIMIT = 4 * (1 << W);
  localparam int NRAND      = 40;

  localparam logic [W-1:0] VEC_A   [NVEC] = '{8'd4,  8'd24, 8'd17, 8'd13, 8'd1,   8'd255, 8'd1,
                                              8'd255, 8'd255, 8'd0, 8'd9, 8'd0, 8'd128, 8'd252};
  localparam logic [W-1:0] VEC_B   [NVEC] = '{8'd24, 8'd4,  8'd17, 8'd8,  8'd200, 8'd1,   8'd255,
                                              8'd255, 8'd85, 8'd9, 8'd0, 8'd0, 8'd96,  8'd198};
  localparam logic [W-1:0] VEC_EXP [NVEC] = '{8'd4,  8'd4,  8'd17, 8'd1,  8'd1,   8'd1,   8'd1,
                                              8'd255, 8'd85, 8'd9, 8'd9, 8'd0, 8'd32,  8'd18};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         done;
  logic [W-1:0] result;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcd_unit #(.WIDTH(W)) i_gcd_unit (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dataIn (dataIn),
    .done   (done),
    .result (result)
  );

  function automatic logic [W-1:0] refGcd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x = a;
    logic [W-1:0] y = b;
    logic [W-1:0] t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int refSubCount(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x = a;
    logic [W-1:0] y = b;
    int n = 0;
    if (x == 0 || y == 0) return 0;
    while (x != y) begin
      if (x > y) x = x - y;
      else y = y - x;
      n++;
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // returns result and the number of edges after the second-operand edge until done
  task automatic runCalc(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke,
                         output logic [W-1:0] res, output int cyc);
    start  = 1'b1;
    dataIn = a;
    @(negedge clk);
    start  = 1'b0;
    dataIn = b;
    @(negedge clk);
    dataIn = 8'hA5;
    cyc = 0;
    while (!done && cyc < CALC_LIMIT) begin
      if (poke && cyc == 3) begin
        start  = 1'b1;
        dataIn = 8'd77;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    res = result;
    if (cyc >= CALC_LIMIT) check(1'b0, "R7 timeout", cyc, CALC_LIMIT);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [W-1:0] res;
    logic [W-1:0] held;
    int cyc;

    // R1: reset state, idle without start
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    dataIn = 8'd99;
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R1 idle without start", int'(done), 0);

    // table walk: R4, R5, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      runCalc(VEC_A[i], VEC_B[i], 1'b0, res, cyc);
      check(res == VEC_EXP[i], "R7 table result", int'(res), int'(VEC_EXP[i]));
      check(cyc == 1 + 2 * refSubCount(VEC_A[i], VEC_B[i]), "R8 table latency",
            cyc, 1 + 2 * refSubCount(VEC_A[i], VEC_B[i]));
    end

    // R4: the worked example
    runCalc(8'd4, 8'd24, 1'b0, res, cyc);
    check(res == 8'd4, "R4 four and twenty-four", int'(res), 4);

    // R5: zero operands skip iteration
    runCalc(8'd0, 8'd37, 1'b0, res, cyc);
    check(res == 8'd37 && cyc == 1, "R5 zero first operand", int'(res) * 1000 + cyc, 37 * 1000 + 1);
    runCalc(8'd0, 8'd0, 1'b0, res, cyc);
    check(res == 8'd0 && cyc == 1, "R5 both zero", int'(res) * 1000 + cyc, 1);

    // R3: alternation shows as one compare plus one subtract per step (6,3 needs one)
    runCalc(8'd6, 8'd3, 1'b0, res, cyc);
    check(res == 8'd3 && cyc == 3, "R3 single subtract step", int'(res) * 1000 + cyc, 3 * 1000 + 3);
    runCalc(8'd3, 8'd6, 1'b0, res, cyc);
    check(res == 8'd3 && cyc == 3, "R3 subtract into B", int'(res) * 1000 + cyc, 3 * 1000 + 3);

    // R6: hold while done, dataIn toggling
    held = result;
    for (int k = 0; k < 6; k++) begin
      dataIn = 8'(k * 41);
      @(negedge clk);
      check(done == 1'b1 && result == held, "R6 hold while done", int'(result), int'(held));
    end
    // R6: start from done drops done on the same edge
    start  = 1'b1;
    dataIn = 8'd50;
    @(negedge clk);
    start  = 1'b0;
    check(done == 1'b0, "R6 done drops on new start", int'(done), 0);
    dataIn = 8'd20;
    @(negedge clk);
    while (!done) @(negedge clk);
    check(result == 8'd10, "R6 restart result", int'(result), 10);

    // R2: start pulse during iteration ignored
    runCalc(8'd200, 8'd3, 1'b1, res, cyc);
    check(res == 8'd1, "R2 start ignored mid-run", int'(res), 1);
    check(cyc == 1 + 2 * refSubCount(8'd200, 8'd3), "R2 latency unchanged",
          cyc, 1 + 2 * refSubCount(8'd200, 8'd3));

    // R1: reset in the middle of a calculation
    start = 1'b1; dataIn = 8'd250;
    @(negedge clk);
    start = 1'b0; dataIn = 8'd1;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset mid-run", int'(done), 0);

    // R7: random pairs against the modulo model
    for (int i = 0; i < NRAND; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = W'($urandom_range(0, (1 << W) - 1));
      b = W'($urandom_range(0, (1 << W) - 1));
      runCalc(a, b, 1'b0, res, cyc);
      check(res == refGcd(a, b), "R7 random pair", int'(res), int'(refGcd(a, b)));
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule